// File: doc/BRIEF.md
# Chainable Event Counter Pair

This block holds two 64-bit event counters, slot 0 (even) and slot 1 (odd). Every counted event adds one to the whole 64-bit value. A single mode input decides only where an overflow is reported. In the narrow mode the report comes when the low 32 bits wrap. In the wide mode it comes only when all 64 bits wrap. The counting itself is the same in both modes.

When chaining is on, the odd counter ignores its own event input. It then advances once for each time the low 32 bits of the even counter wrap. Each counter can be loaded with a full 64-bit value through a write strobe. Overflows are held in a two-bit sticky register that software clears by writing ones. An interrupt request is raised while any overflow bit is set and that bit's enable input is high.

Top module: `evcnt_pair_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both counters read 0, the overflow status reads 0b00 and the interrupt request is low.
- R2: An event on a counter that is not being written adds exactly one to all 64 bits in the next cycle. Without an event or a write the counter holds its value.
- R3: With `ovf_wide_i` = 0, an increment that carries out of bits [31:0] sets that counter's status bit (bit 0 for even, bit 1 for odd) in the next cycle.
- R4: With `ovf_wide_i` = 1, an increment sets the status bit only when it carries out of bits [63:0]. A carry out of bits [31:0] alone sets nothing.
- R5: With `chain_en_i` = 1, the odd counter adds one exactly when the even counter's low 32 bits wrap on an increment, whatever `ovf_wide_i` is, and `ev_odd_i` has no effect. From even = 0xFFFFFFFF and odd = 0 in narrow mode, one even event gives even = 0x1_00000000, odd = 1 and status 0b01. From odd = 0xFFFFFFFF instead, it gives odd = 0x1_00000000 and status 0b11.
- R6: With `chain_en_i` = 0, the odd counter counts `ev_odd_i` under the same boundary rule as the even counter.
- R7: A write strobe (`wr_en_i` bit 0 for even, bit 1 for odd) loads all 64 bits of `wr_data_i` in the next cycle. It takes priority over an event in the same cycle and never sets a status bit or feeds the chain.
- R8: Status bits stay set until a one is written to the matching bit of `ovf_clr_i`. A set in the same cycle as the clear leaves the bit set.
- R9: `irq_o` is high exactly when some status bit is set and the same bit of `irq_en_i` is high. It follows `irq_en_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_even_i | input | 1 | Event pulse for the even counter |
| ev_odd_i | input | 1 | Event pulse for the odd counter (ignored when chained) |
| chain_en_i | input | 1 | 1: odd counter counts the even counter's 32-bit wraps |
| ovf_wide_i | input | 1 | 0: overflow at the 32-bit wrap, 1: overflow at the 64-bit wrap |
| wr_en_i | input | 2 | Per-counter write strobe, bit 0 even, bit 1 odd |
| wr_data_i | input | 64 | Value loaded by a write strobe |
| ovf_clr_i | input | 2 | Write-one-to-clear strobes for the status bits |
| irq_en_i | input | 2 | Per-bit interrupt enables |
| cnt_even_o | output | 64 | Even counter value |
| cnt_odd_o | output | 64 | Odd counter value |
| ovf_o | output | 2 | Sticky overflow status, bit 0 even, bit 1 odd |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong counter state shows on the counter outputs one cycle after the step that produced it. The bench compares both full 64-bit values every cycle, so an error in the upper half or a missed carry appears at once. A wrong wrap decision reaches the status bits and, when chained, the odd counter in that same cycle. Because the status bits are sticky, a spurious set stays visible until it is cleared. The bench therefore loads values just below both wrap points, in both modes, with and without chaining, so that each boundary decision is seen directly.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
    localparam int DEF_CNT_W = 64;
    localparam int DEF_LO_W  = 32;
    localparam int DEF_SLOTS = 2;

    typedef enum logic {
        SPAN_LOW  = 1'b0,
        SPAN_FULL = 1'b1
    } ovf_span_e;
endpackage

// File: rtl/evcnt_unit.sv
module evcnt_unit
    import evcnt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int LO_W  = DEF_LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  ovf_span_e        span_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_lo_o,
    output logic             ovf_evt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic     wrap_full;

    always_comb begin
        st_d      = st_q;
        wrap_lo_o = 1'b0;
        wrap_full = 1'b0;
        if (wr_i) begin
            st_d.cnt = wr_data_i;
        end else if (inc_i) begin
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            wrap_lo_o = &st_q.cnt[LO_W-1:0];
            wrap_full = &st_q.cnt;
        end
        ovf_evt_o = (span_i == SPAN_FULL) ? wrap_full : wrap_lo_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R2: full-width increment, hold otherwise
    assert_inc_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && inc_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !inc_i) |=> $stable(cnt_o));
    // R7: write loads the value and never reports an overflow
    assert_write_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_o == $past(wr_data_i)));
    assert_write_no_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (!ovf_evt_o && !wrap_lo_o));
    // R4: wide span reports only a full wrap
    assert_wide_full_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((span_i == SPAN_FULL) && !(&cnt_o)) |-> !ovf_evt_o);
endmodule

// File: rtl/evcnt_flags.sv
module evcnt_flags
    import evcnt_pkg::*;
#(
    parameter int N = DEF_SLOTS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign irq_o   = |(st_q.flags & en_i);

    for (genvar k = 0; k < N; k++) begin : g_chk
        // R8: sticky until cleared, set beats clear, clear works
        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[k] && !clr_i[k]) |=> flags_o[k]);
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flags_o[k]);
        assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !flags_o[k]);
    end
endmodule

// File: rtl/evcnt_pair_top.sv
module evcnt_pair_top
    import evcnt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int LO_W  = DEF_LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_even_i,
    input  logic             ev_odd_i,
    input  logic             chain_en_i,
    input  logic             ovf_wide_i,
    input  logic [1:0]       wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [1:0]       ovf_clr_i,
    input  logic [1:0]       irq_en_i,
    output logic [CNT_W-1:0] cnt_even_o,
    output logic [CNT_W-1:0] cnt_odd_o,
    output logic [1:0]       ovf_o,
    output logic             irq_o
);
    localparam int SLOTS = 2;

    logic [SLOTS-1:0]            ev_vec, inc_vec, wrap_lo, ovf_set;
    logic [SLOTS-1:0][CNT_W-1:0] cnt_vec;
    ovf_span_e                   span;

    assign ev_vec = {ev_odd_i, ev_even_i};
    assign span   = ovf_wide_i ? SPAN_FULL : SPAN_LOW;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g == 0) begin : g_head
            assign inc_vec[g] = ev_vec[g];
        end else begin : g_link
            assign inc_vec[g] = chain_en_i ? wrap_lo[g-1] : ev_vec[g];
        end

        evcnt_unit #(.CNT_W(CNT_W), .LO_W(LO_W)) i_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (inc_vec[g]),
            .wr_i      (wr_en_i[g]),
            .wr_data_i (wr_data_i),
            .span_i    (span),
            .cnt_o     (cnt_vec[g]),
            .wrap_lo_o (wrap_lo[g]),
            .ovf_evt_o (ovf_set[g])
        );
    end

    evcnt_flags #(.N(SLOTS)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (ovf_set),
        .clr_i   (ovf_clr_i),
        .en_i    (irq_en_i),
        .flags_o (ovf_o),
        .irq_o   (irq_o)
    );

    assign cnt_even_o = cnt_vec[0];
    assign cnt_odd_o  = cnt_vec[1];

    // R5: chained odd counter steps once per even low wrap
    assert_chain_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_en_i && !wr_en_i[1] && wrap_lo[0]) |=> (cnt_odd_o == $past(cnt_odd_o) + CNT_W'(1)));
    assert_chain_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_en_i && !wr_en_i[1] && !wrap_lo[0]) |=> $stable(cnt_odd_o));
    // R3: a narrow-mode low wrap of the odd counter reaches its status bit
    assert_odd_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_wide_i && wrap_lo[1]) |=> ovf_o[1]);
    // R9: interrupt follows the enabled status bits
    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o == 2'b00) |-> !irq_o);
    assert_irq_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o[0] && irq_en_i[0]) |-> irq_o);
endmodule

// File: tb/test_evcnt_pair_top.sv
module test_evcnt_pair_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_even_i = 1'b0, ev_odd_i = 1'b0, chain_en_i = 1'b0, ovf_wide_i = 1'b0;
    logic [1:0]  wr_en_i = '0, ovf_clr_i = '0, irq_en_i = '0;
    logic [63:0] wr_data_i = '0;
    logic [63:0] cnt_even_o, cnt_odd_o;
    logic [1:0]  ovf_o;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [63:0] m_cnt [2];
    logic [1:0]  m_ovf;

    always #2 clk = ~clk;

    evcnt_pair_top i_evcnt_pair_top (
        .clk(clk), .rst_n(rst_n), .ev_even_i(ev_even_i), .ev_odd_i(ev_odd_i),
        .chain_en_i(chain_en_i), .ovf_wide_i(ovf_wide_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .ovf_clr_i(ovf_clr_i), .irq_en_i(irq_en_i),
        .cnt_even_o(cnt_even_o), .cnt_odd_o(cnt_odd_o), .ovf_o(ovf_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "even", cnt_even_o, m_cnt[0]);
        check(tag, "odd", cnt_odd_o, m_cnt[1]);
        check(tag, "ovf", {62'd0, ovf_o}, {62'd0, m_ovf});
        check(tag, "irq", {63'd0, irq_o}, {63'd0, |(m_ovf & irq_en_i)});
    endtask

    // drive at a falling edge, let one rising edge pass, compare at the next falling edge
    task automatic step(input string tag, input bit ee, input bit eo, input bit ch,
                        input bit wd, input bit [1:0] wr, input logic [63:0] wdat,
                        input bit [1:0] clr, input bit [1:0] en);
        bit lo0, hi0, lo1, hi1, inc1;
        bit [1:0] setv;
        ev_even_i = ee; ev_odd_i = eo; chain_en_i = ch; ovf_wide_i = wd;
        wr_en_i = wr; wr_data_i = wdat; ovf_clr_i = clr; irq_en_i = en;
        @(posedge clk);
        lo0 = !wr[0] && ee && (m_cnt[0][31:0] == 32'hFFFF_FFFF);
        hi0 = !wr[0] && ee && (m_cnt[0] == 64'hFFFF_FFFF_FFFF_FFFF);
        inc1 = ch ? lo0 : eo;
        lo1 = !wr[1] && inc1 && (m_cnt[1][31:0] == 32'hFFFF_FFFF);
        hi1 = !wr[1] && inc1 && (m_cnt[1] == 64'hFFFF_FFFF_FFFF_FFFF);
        setv = wd ? {hi1, hi0} : {lo1, lo0};
        if (wr[0]) m_cnt[0] = wdat; else if (ee) m_cnt[0] = m_cnt[0] + 64'd1;
        if (wr[1]) m_cnt[1] = wdat; else if (inc1) m_cnt[1] = m_cnt[1] + 64'd1;
        m_ovf = (m_ovf & ~clr) | setv;
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic load(input string tag, input logic [63:0] e, input logic [63:0] o);
        step(tag, 0, 0, 0, 0, 2'b01, e, 2'b00, 2'b00);
        step(tag, 0, 0, 0, 0, 2'b10, o, 2'b11, 2'b00);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        m_cnt[0] = '0; m_cnt[1] = '0; m_ovf = '0;
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R2 / R6: plain counting, odd on its own input
        for (int i = 0; i < 5; i++) step("R2", 1, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step("R6", 0, 1, 0, 0, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
        // R7: write beats event, loads 64 bits, no status
        step("R7", 1, 1, 0, 0, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'b11);
        step("R7", 0, 0, 0, 0, 2'b00, 0, 0, 2'b11);
        // R2: carry into the upper half in narrow mode
        load("R2", 64'h0000_0000_FFFF_FFFE, 64'h1234_5678_9ABC_DEF0);
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R3", 1, 0, 0, 0, 0, 0, 0, 0);
        // R5: the two chained examples
        load("R5", 64'h0000_0000_FFFF_FFFF, 64'h0);
        step("R5", 1, 0, 1, 0, 0, 0, 0, 0);
        load("R5", 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF);
        step("R5", 1, 0, 1, 0, 0, 0, 0, 0);
        // R5: odd event ignored while chained
        step("R5", 0, 1, 1, 0, 0, 0, 2'b11, 0);
        step("R5", 0, 1, 1, 0, 0, 0, 0, 0);
        // R4: wide mode, low wrap sets nothing, chain still fires
        load("R4", 64'h0000_0000_FFFF_FFFF, 64'h5);
        step("R4", 1, 0, 1, 1, 0, 0, 0, 0);
        load("R4", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE);
        step("R4", 1, 1, 0, 1, 0, 0, 0, 0);
        step("R4", 0, 1, 0, 1, 0, 0, 0, 0);
        // R6: unchained odd low wrap in narrow mode
        load("R6", 64'h0, 64'h0000_0007_FFFF_FFFF);
        step("R6", 0, 1, 0, 0, 0, 0, 0, 0);
        // R8: sticky, clear, set-beats-clear
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 2'b01, 0);
        load("R8", 64'h0000_0000_FFFF_FFFF, 64'h0);
        step("R8", 1, 0, 0, 0, 0, 0, 2'b01, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0);
        // R9: enables gate the request
        step("R9", 0, 0, 0, 0, 0, 0, 0, 2'b00);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 2'b10);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 2'b01);
        step("R9", 0, 0, 0, 0, 0, 0, 2'b01, 2'b01);
        // mixed patterns near both wrap points
        r = 32'hACE1_2345;
        for (int i = 0; i < 400; i++) begin
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            if (r[7:4] == 4'h0)
                step("R2", r[0], r[1], r[2], r[3], r[9:8],
                     r[10] ? {60'hFFFF_FFFF_FFFF_FFF, r[15:12]} : {32'h0, 28'hFFFF_FFF, r[15:12]},
                     r[17:16], r[19:18]);
            else
                step("R2", r[0], r[1], r[2], r[3], 2'b00, 0, {r[20] & r[21], r[22] & r[23]},
                     r[19:18]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule